// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM

This block is a synchronous true dual-port word store. A left and a right port each have their own address, write data, read data and active-low controls: chip select, read/write direction, output enable, upper-lane select, lower-lane select and a special-space select. Each 18-bit word is split into two 9-bit lanes. A port writes or returns only the lanes it selects, and it flags each returned lane with a valid bit. The valid bit takes the place of a driven or floating pin.

Both ports run from one clock. Read data is registered, so it appears one clock after the address and controls are sampled. When both ports write the same word in the same cycle, the left port wins. The right port sees its busy output raised in that cycle and its write is dropped. The word count is `2**ADDR_W`. The full-size configuration sets `ADDR_W = 13` (8192 words); the default is smaller so that it elaborates quickly.

Top module: `dpram_lanes`

## Requirements
- R1: The store holds `2**ADDR_W` words of 18 bits. Lane 0 is bits 8:0 and is selected by `*_lb_n` low. Lane 1 is bits 17:9 and is selected by `*_ub_n` low. A word written through either port reads back unchanged through either port.
- R2: While `*_cs_n` is high, the port neither writes nor reads. Its `*_rvalid` is 2'b00 one clock later and the stored word is unchanged.
- R3: While `*_ub_n` and `*_lb_n` are both high, the port makes no access: nothing is written and `*_rvalid` is 2'b00 one clock later.
- R4: With `*_cs_n` low and `*_we_n` low, only the lanes whose select is low are written. The other lane keeps its old contents, and `*_oe_n` has no effect on the write.
- R5: With `*_cs_n` low, `*_we_n` high and `*_oe_n` low, the selected lanes return the stored data one clock later. `*_rvalid[0]` flags lane 0 and `*_rvalid[1]` flags lane 1. A lane whose valid bit is low reads as zero.
- R6: A read with `*_oe_n` high returns no lanes: `*_rvalid` is 2'b00 one clock later.
- R7: While `*_sem_n` is low, the port makes no memory access, neither read nor write.
- R8: Both ports may read the same word in the same cycle, and both receive the stored data.
- R9: When both ports write the same address in the same cycle, the left port's data is stored. `r_busy` is high during that cycle and none of the right port's lanes is written. `l_busy` stays low.
- R10: When one port writes a word and the other port reads the same address in the same cycle, the reader receives the data stored before the write.
- R11: Reset is synchronous and active low. During reset no access occurs and both busy outputs are low. After a reset clock, rdata is zero and rvalid is 2'b00. Stored words survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left direction: low writes, high reads |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper-lane select, active low |
| l_lb_n | input | 1 | Left lower-lane select, active low |
| l_sem_n | input | 1 | Left special-space select; low blocks memory access |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data, zero in lanes not valid |
| l_rvalid | output | 2 | Left per-lane read valid, bit 0 = lower lane |
| l_busy | output | 1 | Left port lost a write collision |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right direction: low writes, high reads |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper-lane select, active low |
| r_lb_n | input | 1 | Right lower-lane select, active low |
| r_sem_n | input | 1 | Right special-space select; low blocks memory access |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data, zero in lanes not valid |
| r_rvalid | output | 2 | Right per-lane read valid, bit 0 = lower lane |
| r_busy | output | 1 | Right port lost a write collision |

## Verification
Three kinds of overlap are driven on purpose. The bench issues a write on one port and a read on the other to one address in the same cycle, and the reader must return the word that was stored before the write. It issues writes from both ports to one address with different data, and it expects `r_busy` during that cycle and only the left data when the word is read back afterwards. It also issues identical reads from both ports, and it expects both to return the same stored word.

// File: rtl/dpram_pkg.sv
// Package: shared lane geometry and the decoded per-port operation type.
// Assumes a word made of two equal lanes; lane 0 is the low lane.
package dpram_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    // Decoded request of one port for the current cycle.
    typedef struct packed {
        logic [LANES-1:0] wr_lanes;
        logic [LANES-1:0] rd_lanes;
    } port_op_t;

    // Turn the active-low lane selects into an active-high lane mask.
    function automatic logic [LANES-1:0] lane_mask(input logic ub_n, input logic lb_n);
        return {~ub_n, ~lb_n};
    endfunction
endpackage

// File: rtl/port_decode.sv
// Module: port_decode
// Decodes the active-low controls of one port into per-lane write and read
// masks. Assumes all inputs are synchronous to the block clock. During reset
// every mask is zero, so no access can start.
module port_decode
    import dpram_pkg::*;
(
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     we_n,
    input  logic     oe_n,
    input  logic     ub_n,
    input  logic     lb_n,
    input  logic     sem_n,
    output port_op_t op
);
    logic             active;
    logic [LANES-1:0] sel;

    // Build the write and read lane masks from the control levels.
    always_comb begin
        active      = rst_n & ~cs_n & sem_n;
        sel         = lane_mask(ub_n, lb_n);
        op.wr_lanes = (active & ~we_n)         ? sel : '0;
        op.rd_lanes = (active & we_n & ~oe_n)  ? sel : '0;
    end
endmodule

// File: rtl/collision_arb.sv
// Module: collision_arb
// Detects two writes to the same word in one cycle and blocks the loser.
// LEFT_WINS selects the winning side. Assumes the write masks are already
// gated by chip select, the special-space select and reset.
module collision_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter bit LEFT_WINS = 1'b1
) (
    input  logic [LANES-1:0]  l_wr,
    input  logic [LANES-1:0]  r_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic [LANES-1:0]  l_wr_ok,
    output logic [LANES-1:0]  r_wr_ok,
    output logic              l_busy,
    output logic              r_busy
);
    logic clash;

    // Flag a same-address write pair.
    always_comb clash = (|l_wr) & (|r_wr) & (l_addr == r_addr);

    generate
        if (LEFT_WINS) begin : g_left
            // Right side yields on a clash.
            always_comb begin
                l_wr_ok = l_wr;
                r_wr_ok = clash ? '0 : r_wr;
                l_busy  = 1'b0;
                r_busy  = clash;
            end
        end else begin : g_right
            // Left side yields on a clash.
            always_comb begin
                l_wr_ok = clash ? '0 : l_wr;
                r_wr_ok = r_wr;
                l_busy  = clash;
                r_busy  = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/lane_bank.sv
// Module: lane_bank
// One lane of storage with two ports and a registered read on each port.
// Assumes the two write enables never address the same word in one cycle
// (the arbiter guarantees this). A read returns the contents from before any
// write in the same cycle. The storage itself is not reset.
module lane_bank #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store lane data from either port.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
    end

    // Register port A read data; zero when the lane is not read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata  <= '0;
            a_rvalid <= 1'b0;
        end else begin
            a_rvalid <= a_re;
            a_rdata  <= a_re ? mem[a_addr] : '0;
        end
    end

    // Register port B read data; zero when the lane is not read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_rdata  <= '0;
            b_rvalid <= 1'b0;
        end else begin
            b_rvalid <= b_re;
            b_rdata  <= b_re ? mem[b_addr] : '0;
        end
    end
endmodule

// File: rtl/dpram_lanes.sv
// Module: dpram_lanes
// Synchronous dual-port RAM with two byte lanes per word. It decodes each
// port's controls, arbitrates same-word write collisions and instantiates one
// storage bank per lane. Assumes both ports share clk. The full-size
// configuration is ADDR_W = 13.
module dpram_lanes
    import dpram_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter bit LEFT_WINS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic              l_sem_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [17:0]       l_wdata,
    output logic [17:0]       l_rdata,
    output logic [1:0]        l_rvalid,
    output logic              l_busy,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic              r_sem_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [17:0]       r_wdata,
    output logic [17:0]       r_rdata,
    output logic [1:0]        r_rvalid,
    output logic              r_busy
);
    port_op_t         l_op, r_op;
    logic [LANES-1:0] l_wr_ok, r_wr_ok;

    port_decode i_l_dec (
        .rst_n (rst_n), .cs_n (l_cs_n), .we_n (l_we_n), .oe_n (l_oe_n),
        .ub_n  (l_ub_n), .lb_n (l_lb_n), .sem_n (l_sem_n), .op (l_op)
    );

    port_decode i_r_dec (
        .rst_n (rst_n), .cs_n (r_cs_n), .we_n (r_we_n), .oe_n (r_oe_n),
        .ub_n  (r_ub_n), .lb_n (r_lb_n), .sem_n (r_sem_n), .op (r_op)
    );

    collision_arb #(.ADDR_W(ADDR_W), .LEFT_WINS(LEFT_WINS)) i_arb (
        .l_wr    (l_op.wr_lanes),
        .r_wr    (r_op.wr_lanes),
        .l_addr  (l_addr),
        .r_addr  (r_addr),
        .l_wr_ok (l_wr_ok),
        .r_wr_ok (r_wr_ok),
        .l_busy  (l_busy),
        .r_busy  (r_busy)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            lane_bank #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) i_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .a_we     (l_wr_ok[g]),
                .a_re     (l_op.rd_lanes[g]),
                .a_addr   (l_addr),
                .a_wdata  (l_wdata[g*LANE_W +: LANE_W]),
                .a_rdata  (l_rdata[g*LANE_W +: LANE_W]),
                .a_rvalid (l_rvalid[g]),
                .b_we     (r_wr_ok[g]),
                .b_re     (r_op.rd_lanes[g]),
                .b_addr   (r_addr),
                .b_wdata  (r_wdata[g*LANE_W +: LANE_W]),
                .b_rdata  (r_rdata[g*LANE_W +: LANE_W]),
                .b_rvalid (r_rvalid[g])
            );
        end
    endgenerate
endmodule

// File: rtl/dpram_lanes_chk.sv
// Module: dpram_lanes_chk
// Protocol checker bound to dpram_lanes. It checks lane-valid timing, zero
// fill and collision flags from the ports only.
module dpram_lanes_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_cs_n,
    input logic              l_we_n,
    input logic              l_oe_n,
    input logic              l_ub_n,
    input logic              l_lb_n,
    input logic              l_sem_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [17:0]       l_rdata,
    input logic [1:0]        l_rvalid,
    input logic              l_busy,
    input logic              r_cs_n,
    input logic              r_we_n,
    input logic              r_oe_n,
    input logic              r_ub_n,
    input logic              r_lb_n,
    input logic              r_sem_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [17:0]       r_rdata,
    input logic [1:0]        r_rvalid,
    input logic              r_busy
);
    a_r2_deselect_l: assert property (@(posedge clk) disable iff (!rst_n)
        l_cs_n |=> (l_rvalid == 2'b00));
    a_r2_deselect_r: assert property (@(posedge clk) disable iff (!rst_n)
        r_cs_n |=> (r_rvalid == 2'b00));
    a_r3_no_lanes_l: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ub_n && l_lb_n) |=> (l_rvalid == 2'b00));
    a_r5_lane_valid_l: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && l_we_n && !l_oe_n && l_sem_n) |=> (l_rvalid == ~$past({l_ub_n, l_lb_n})));
    a_r5_lane_valid_r: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_cs_n && r_we_n && !r_oe_n && r_sem_n) |=> (r_rvalid == ~$past({r_ub_n, r_lb_n})));
    a_r5_zero_low_l: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rvalid[0] |-> (l_rdata[8:0] == 9'd0));
    a_r5_zero_high_r: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rvalid[1] |-> (r_rdata[17:9] == 9'd0));
    a_r6_oe_off_l: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && l_we_n && l_oe_n) |=> (l_rvalid == 2'b00));
    a_r7_sem_block_r: assert property (@(posedge clk) disable iff (!rst_n)
        !r_sem_n |=> (r_rvalid == 2'b00));
    a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy |-> (!l_cs_n && !l_we_n && l_sem_n && !r_we_n && (l_addr == r_addr)));
    a_r9_left_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy |-> !l_busy);
endmodule

bind dpram_lanes dpram_lanes_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk (clk), .rst_n (rst_n),
    .l_cs_n (l_cs_n), .l_we_n (l_we_n), .l_oe_n (l_oe_n), .l_ub_n (l_ub_n),
    .l_lb_n (l_lb_n), .l_sem_n (l_sem_n), .l_addr (l_addr), .l_rdata (l_rdata),
    .l_rvalid (l_rvalid), .l_busy (l_busy),
    .r_cs_n (r_cs_n), .r_we_n (r_we_n), .r_oe_n (r_oe_n), .r_ub_n (r_ub_n),
    .r_lb_n (r_lb_n), .r_sem_n (r_sem_n), .r_addr (r_addr), .r_rdata (r_rdata),
    .r_rvalid (r_rvalid), .r_busy (r_busy)
);

// File: tb/test_dpram_lanes.sv
// Bench for dpram_lanes: a behavioural model (associative array) is stepped
// once per clock and compared against the outputs on every clock.
module test_dpram_lanes;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 11;

    logic clk = 1'b0;
    logic rst_n;
    logic l_cs_n, l_we_n, l_oe_n, l_ub_n, l_lb_n, l_sem_n;
    logic r_cs_n, r_we_n, r_oe_n, r_ub_n, r_lb_n, r_sem_n;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic [17:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic [1:0]  l_rvalid, r_rvalid;
    logic        l_busy, r_busy;

    int n_tests = 0;
    int n_fail  = 0;
    logic [17:0] ref_mem [int];

    always #(CLK_P/2) clk = ~clk;

    dpram_lanes #(.ADDR_W(ADDR_W)) i_dpram_lanes (
        .clk (clk), .rst_n (rst_n),
        .l_cs_n (l_cs_n), .l_we_n (l_we_n), .l_oe_n (l_oe_n), .l_ub_n (l_ub_n),
        .l_lb_n (l_lb_n), .l_sem_n (l_sem_n), .l_addr (l_addr), .l_wdata (l_wdata),
        .l_rdata (l_rdata), .l_rvalid (l_rvalid), .l_busy (l_busy),
        .r_cs_n (r_cs_n), .r_we_n (r_we_n), .r_oe_n (r_oe_n), .r_ub_n (r_ub_n),
        .r_lb_n (r_lb_n), .r_sem_n (r_sem_n), .r_addr (r_addr), .r_wdata (r_wdata),
        .r_rdata (r_rdata), .r_rvalid (r_rvalid), .r_busy (r_busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [17:0] act, input logic [17:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_ub_n = 0; l_lb_n = 0; l_sem_n = 1;
        r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_ub_n = 0; r_lb_n = 0; r_sem_n = 1;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    endtask

    task automatic set_l(input bit wr, input bit oe_n, input bit ub_n, input bit lb_n,
                         input int a, input logic [17:0] d);
        l_cs_n = 0; l_we_n = !wr; l_oe_n = oe_n; l_ub_n = ub_n; l_lb_n = lb_n;
        l_addr = a[ADDR_W-1:0]; l_wdata = d;
    endtask

    task automatic set_r(input bit wr, input bit oe_n, input bit ub_n, input bit lb_n,
                         input int a, input logic [17:0] d);
        r_cs_n = 0; r_we_n = !wr; r_oe_n = oe_n; r_ub_n = ub_n; r_lb_n = lb_n;
        r_addr = a[ADDR_W-1:0]; r_wdata = d;
    endtask

    // One clock: check busy now, step the model at the edge, check reads after.
    task automatic tick(input string req);
        logic [1:0] lw, rw, lr, rr;
        logic       l_act, r_act, clash;
        logic [17:0] le, re, old;
        int la, ra;
        #1;
        l_act = rst_n && !l_cs_n && l_sem_n;
        r_act = rst_n && !r_cs_n && r_sem_n;
        lw = (l_act && !l_we_n) ? {~l_ub_n, ~l_lb_n} : 2'b00;
        rw = (r_act && !r_we_n) ? {~r_ub_n, ~r_lb_n} : 2'b00;
        lr = (l_act && l_we_n && !l_oe_n) ? {~l_ub_n, ~l_lb_n} : 2'b00;
        rr = (r_act && r_we_n && !r_oe_n) ? {~r_ub_n, ~r_lb_n} : 2'b00;
        la = int'(l_addr); ra = int'(r_addr);
        clash = (|lw) && (|rw) && (la == ra);
        chk(r_busy === clash, req, "r_busy", {17'd0, r_busy}, {17'd0, clash});
        chk(l_busy === 1'b0, req, "l_busy", {17'd0, l_busy}, 18'd0);
        @(posedge clk);
        le = ref_mem.exists(la) ? ref_mem[la] : 18'bx;
        re = ref_mem.exists(ra) ? ref_mem[ra] : 18'bx;
        if (|lw) begin
            old = ref_mem.exists(la) ? ref_mem[la] : 18'bx;
            if (lw[0]) old[8:0]  = l_wdata[8:0];
            if (lw[1]) old[17:9] = l_wdata[17:9];
            ref_mem[la] = old;
        end
        if ((|rw) && !clash) begin
            old = ref_mem.exists(ra) ? ref_mem[ra] : 18'bx;
            if (rw[0]) old[8:0]  = r_wdata[8:0];
            if (rw[1]) old[17:9] = r_wdata[17:9];
            ref_mem[ra] = old;
        end
        @(negedge clk);
        chk(l_rvalid === lr, req, "l_rvalid", {16'd0, l_rvalid}, {16'd0, lr});
        chk(r_rvalid === rr, req, "r_rvalid", {16'd0, r_rvalid}, {16'd0, rr});
        for (int g = 0; g < 2; g++) begin
            if (!lr[g]) chk(l_rdata[g*9 +: 9] === 9'd0, req, "l_rdata zero lane", l_rdata, 18'd0);
            else if (!$isunknown(le[g*9 +: 9]))
                chk(l_rdata[g*9 +: 9] === le[g*9 +: 9], req, "l_rdata lane", l_rdata, le);
            if (!rr[g]) chk(r_rdata[g*9 +: 9] === 9'd0, req, "r_rdata zero lane", r_rdata, 18'd0);
            else if (!$isunknown(re[g*9 +: 9]))
                chk(r_rdata[g*9 +: 9] === re[g*9 +: 9], req, "r_rdata lane", r_rdata, re);
        end
        idle();
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        tick("R11");
        tick("R11");
        rst_n = 1;
        // R1: full-word write left, read back on both ports
        set_l(1, 1, 0, 0, 5, 18'h2A5C3); tick("R1");
        set_l(0, 0, 0, 0, 5, 0); tick("R1");
        set_r(0, 0, 0, 0, 5, 0); tick("R1");
        // R4: lower-lane write from right with oe low; upper lane keeps old data
        set_r(1, 0, 1, 0, 5, 18'h3FF11); tick("R4");
        set_l(0, 0, 0, 0, 5, 0); tick("R4");
        set_l(1, 1, 0, 1, 5, 18'h155AA); tick("R4");
        set_r(0, 0, 0, 0, 5, 0); tick("R4");
        // R2: deselected port neither writes nor reads
        set_l(1, 1, 0, 0, 5, 18'h00000); l_cs_n = 1; tick("R2");
        set_l(0, 0, 0, 0, 5, 0); l_cs_n = 1; tick("R2");
        set_r(0, 0, 0, 0, 5, 0); tick("R2");
        // R3: both lane selects high
        set_l(1, 1, 1, 1, 5, 18'h12345); tick("R3");
        set_l(0, 0, 1, 1, 5, 0); tick("R3");
        set_l(0, 0, 0, 0, 5, 0); tick("R3");
        // R6: output enable high during read
        set_r(0, 1, 0, 0, 5, 0); tick("R6");
        // R7: special-space select blocks write and read
        set_r(1, 1, 0, 0, 5, 18'h0BEEF); r_sem_n = 0; tick("R7");
        set_r(0, 0, 0, 0, 5, 0); r_sem_n = 0; tick("R7");
        set_l(0, 0, 0, 0, 5, 0); tick("R7");
        // R5: upper-only and lower-only reads
        set_l(0, 0, 0, 1, 5, 0); set_r(0, 0, 1, 0, 5, 0); tick("R5");
        // R8: both ports read the same word
        set_l(1, 1, 0, 0, 9, 18'h1C0DE); tick("R8");
        set_l(0, 0, 0, 0, 9, 0); set_r(0, 0, 0, 0, 9, 0); tick("R8");
        // R9: same-word write collision, left wins
        set_l(1, 1, 0, 0, 7, 18'h11111); set_r(1, 1, 0, 0, 7, 18'h22222); tick("R9");
        set_l(0, 0, 0, 0, 7, 0); set_r(0, 0, 0, 0, 7, 0); tick("R9");
        set_l(1, 1, 1, 0, 7, 18'h00033); set_r(1, 1, 0, 1, 7, 18'h3FE00); tick("R9");
        set_r(0, 0, 0, 0, 7, 0); tick("R9");
        // R9: different addresses do not collide
        set_l(1, 1, 0, 0, 3, 18'h00444); set_r(1, 1, 0, 0, 4, 18'h00555); tick("R9");
        set_l(0, 0, 0, 0, 4, 0); set_r(0, 0, 0, 0, 3, 0); tick("R9");
        // R10: read and write the same word on opposite ports
        set_l(1, 1, 0, 0, 9, 18'h2FACE); set_r(0, 0, 0, 0, 9, 0); tick("R10");
        set_r(1, 1, 0, 0, 9, 18'h0F0F0); set_l(0, 0, 0, 0, 9, 0); tick("R10");
        set_l(0, 0, 0, 0, 9, 0); tick("R10");
        // R11: reset in mid-run keeps stored words and blocks access
        set_l(0, 0, 0, 0, 9, 0); rst_n = 0; tick("R11");
        set_l(1, 1, 0, 0, 9, 18'h00001); rst_n = 0; tick("R11");
        rst_n = 1;
        set_l(0, 0, 0, 0, 9, 0); set_r(0, 0, 0, 0, 5, 0); tick("R11");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule